// File: doc/BRIEF.md
# Event-Queue Message Interrupt Controller

This block turns incoming message-signalled interrupts into entries of per-queue ring buffers that live in host memory. Each arriving message carries a vector number and sixteen bits of payload. A steering table maps the vector to one of the queues. The controller then writes one 32-bit entry at the queue's current tail slot and waits for the memory side to confirm the write. Only after that confirmation does it advance the tail, and the queue's interrupt line follows from the advanced tail.

Software programs a base address for each queue and retargets vectors between queues, which moves an interrupt source to another processor. After it consumes entries, software writes the queue's head pointer. A queue's interrupt line stays high while unconsumed entries remain. While the ring of the message's target queue is full, incoming messages are held off, so no entry is ever overwritten.

Top module: `msi_evq_ctrl`

## Requirements
- R1: The entry for a message is written to address base + 4 × tail of the target queue, where tail is the 6-bit pointer before the write.
- R2: The written word has the message payload in bits 15:0 and the vector number, zero-extended, in bits 31:16.
- R3: Only one message is in flight at a time. `msi_ready` is low from the cycle after an accept until the cycle after `mem_wr_ack`. `mem_wr_valid`, `mem_wr_addr` and `mem_wr_data` hold steady until acknowledged.
- R4: A queue's tail advances by exactly one, modulo 64, at the clock edge where `mem_wr_ack` is seen, and at no other time. The interrupt line cannot rise before that edge.
- R5: `irq[q]` is high exactly when the head and tail of queue q differ. A register write with kind 1 sets the head from `reg_wdata[5:0]`, and writing the tail value clears the line.
- R6: A queue is full when tail + 1 equals head (modulo 64), which is 63 pending entries. While the target queue is full, `msi_ready` is low and no write is issued. Messages bound for other queues are still accepted.
- R7: After reset, vector v is steered to queue v mod NUM_Q. A register write with kind 2 steers vector `reg_idx` to queue `reg_wdata[1:0]`, and this applies to messages accepted after that write.
- R8: A register write with kind 0 sets the base address of queue `reg_idx[1:0]` to `reg_wdata`. Kind 3 has no effect on any state.
- R9: Out of reset, every base, head and tail is zero, no write is requested, every interrupt line is low and `msi_ready` is high.
- R10: The tail wraps from 63 to 0, so the slot after the last one is written at the queue base again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | A message is offered |
| msi_vector | input | 6 | Vector number of the message |
| msi_data | input | 16 | Message payload |
| msi_ready | output | 1 | Message accepted when high together with msi_valid |
| mem_wr_valid | output | 1 | Entry write request pending |
| mem_wr_addr | output | 32 | Byte address of the entry |
| mem_wr_data | output | 32 | Entry word |
| mem_wr_ack | input | 1 | Entry write has completed |
| reg_we | input | 1 | Register write strobe |
| reg_kind | input | 2 | 0 base, 1 head, 2 steering, 3 none |
| reg_idx | input | 6 | Queue index (low bits) or vector number |
| reg_wdata | input | 32 | Register write value |
| irq | output | 4 | One interrupt line per queue |

## Verification
The bench uses the defaults NUM_Q=4, VEC_W=6 and PTR_W=6. Sixty-four vectors spread over four queues let it retarget a vector to a queue it did not reach before. With a 64-slot ring, a single queue fills, stalls and wraps within a few hundred cycles while the other queues keep taking traffic. The acknowledge latency changes between zero and several cycles, which checks that the request holds steady and that the tail and interrupt line wait for the confirmation.

// File: rtl/msi_evq_pkg.sv
package msi_evq_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int PAYLOAD_W = 16;

  typedef enum logic [1:0] {
    REG_BASE  = 2'd0,
    REG_HEAD  = 2'd1,
    REG_STEER = 2'd2,
    REG_NONE  = 2'd3
  } reg_kind_e;

  typedef enum logic {
    ENG_IDLE  = 1'b0,
    ENG_WRITE = 1'b1
  } eng_state_e;

  // byte address of a ring slot: four bytes per entry
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] base,
                                                  input logic [ADDR_W-1:0] ptr);
    return base + (ptr << 2);
  endfunction

  // entry word: tag in the upper half, payload in the lower half
  function automatic logic [WORD_W-1:0] pack_entry(input logic [PAYLOAD_W-1:0] tag,
                                                   input logic [PAYLOAD_W-1:0] payload);
    return {tag, payload};
  endfunction
endpackage

// File: rtl/msi_evq_steer.sv
module msi_evq_steer #(
  parameter int NUM_Q = 4,
  parameter int VEC_W = 6,
  parameter int QW    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VEC_W-1:0] wr_vec,
  input  logic [QW-1:0]    wr_q,
  input  logic [VEC_W-1:0] rd_vec,
  output logic [QW-1:0]    rd_q
);
  localparam int NUM_VEC = 1 << VEC_W;

  logic [QW-1:0] route_tbl [NUM_VEC];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int v = 0; v < NUM_VEC; v++) route_tbl[v] <= QW'(v % NUM_Q);
    end else if (wr_en) begin
      route_tbl[wr_vec] <= wr_q;
    end
  end

  assign rd_q = route_tbl[rd_vec];

  // a steering write is visible on the next lookup of that vector
  assert_steer_update_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (route_tbl[$past(wr_vec)] == $past(wr_q)));
endmodule

// File: rtl/msi_evq_ptrs.sv
module msi_evq_ptrs
  import msi_evq_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int PTR_W = 6,
  parameter int QW    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_we,
  input  logic              head_we,
  input  logic [QW-1:0]     wq,
  input  logic [ADDR_W-1:0] wdata,
  input  logic              commit_en,
  input  logic [QW-1:0]     commit_q,
  input  logic [QW-1:0]     sel_q,
  output logic              sel_full,
  output logic [ADDR_W-1:0] sel_addr,
  output logic [NUM_Q-1:0]  irq
);
  logic [ADDR_W-1:0] base_r [NUM_Q];
  logic [PTR_W-1:0]  head_r [NUM_Q];
  logic [PTR_W-1:0]  tail_r [NUM_Q];
  logic [NUM_Q-1:0]  full_v;

  function automatic logic [PTR_W-1:0] ring_next(input logic [PTR_W-1:0] p);
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int q = 0; q < NUM_Q; q++) begin
        base_r[q] <= '0;
        head_r[q] <= '0;
        tail_r[q] <= '0;
      end
    end else begin
      if (base_we) base_r[wq] <= wdata;
      if (head_we) head_r[wq] <= wdata[PTR_W-1:0];
      if (commit_en) tail_r[commit_q] <= ring_next(tail_r[commit_q]);
    end
  end

  for (genvar i = 0; i < NUM_Q; i++) begin : g_q
    assign full_v[i] = (ring_next(tail_r[i]) == head_r[i]);
    assign irq[i]    = (head_r[i] != tail_r[i]);

    // tail moves only on a confirmed write to this queue, by one slot
    assert_tail_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (tail_r[i] != $past(tail_r[i])) |->
        ($past(commit_en && (commit_q == QW'(i))) &&
         (tail_r[i] == PTR_W'($past(tail_r[i]) + 1))));

    // a line rises only after a tail advance or a head write on that queue
    assert_irq_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[i]) |->
        ($past(commit_en && (commit_q == QW'(i))) || $past(head_we && (wq == QW'(i)))));
  end

  assign sel_full = full_v[sel_q];
  assign sel_addr = slot_addr(base_r[sel_q], ADDR_W'(tail_r[sel_q]));
endmodule

// File: rtl/msi_evq_engine.sv
module msi_evq_engine
  import msi_evq_pkg::*;
#(
  parameter int VEC_W = 6,
  parameter int QW    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 msi_valid,
  input  logic [VEC_W-1:0]     msi_vector,
  input  logic [PAYLOAD_W-1:0] msi_data,
  output logic                 msi_ready,
  input  logic [QW-1:0]        tgt_q,
  input  logic                 tgt_full,
  input  logic [ADDR_W-1:0]    tgt_addr,
  output logic                 mem_wr_valid,
  output logic [ADDR_W-1:0]    mem_wr_addr,
  output logic [WORD_W-1:0]    mem_wr_data,
  input  logic                 mem_wr_ack,
  output logic                 commit_en,
  output logic [QW-1:0]        commit_q
);
  eng_state_e        state;
  logic              accept;
  logic [QW-1:0]     q_r;
  logic [ADDR_W-1:0] addr_r;
  logic [WORD_W-1:0] data_r;

  assign msi_ready = (state == ENG_IDLE) && !tgt_full;
  assign accept    = msi_valid && msi_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ENG_IDLE;
      q_r    <= '0;
      addr_r <= '0;
      data_r <= '0;
    end else begin
      case (state)
        ENG_IDLE: if (accept) begin
          state  <= ENG_WRITE;
          q_r    <= tgt_q;
          addr_r <= tgt_addr;
          data_r <= pack_entry(PAYLOAD_W'(msi_vector), msi_data);
        end
        ENG_WRITE: if (mem_wr_ack) state <= ENG_IDLE;
        default: state <= ENG_IDLE;
      endcase
    end
  end

  assign mem_wr_valid = (state == ENG_WRITE);
  assign mem_wr_addr  = addr_r;
  assign mem_wr_data  = data_r;
  assign commit_en    = mem_wr_valid && mem_wr_ack;
  assign commit_q     = q_r;

  // an unacknowledged request stays put
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ack) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // nothing new is taken while a write is outstanding
  assert_single_flight_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_valid |-> !msi_ready);

  // a request appears only after an accept
  assert_req_from_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wr_valid) |-> $past(msi_valid && msi_ready));
endmodule

// File: rtl/msi_evq_ctrl.sv
module msi_evq_ctrl
  import msi_evq_pkg::*;
#(
  parameter int NUM_Q = 4,
  parameter int VEC_W = 6,
  parameter int PTR_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msi_valid,
  input  logic [VEC_W-1:0] msi_vector,
  input  logic [15:0]      msi_data,
  output logic             msi_ready,
  output logic             mem_wr_valid,
  output logic [31:0]      mem_wr_addr,
  output logic [31:0]      mem_wr_data,
  input  logic             mem_wr_ack,
  input  logic             reg_we,
  input  logic [1:0]       reg_kind,
  input  logic [VEC_W-1:0] reg_idx,
  input  logic [31:0]      reg_wdata,
  output logic [NUM_Q-1:0] irq
);
  localparam int QW = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;

  logic          base_we, head_we, steer_we;
  logic [QW-1:0] tgt_q, commit_q;
  logic          tgt_full, commit_en;
  logic [31:0]   tgt_addr;

  assign base_we  = reg_we && (reg_kind == REG_BASE);
  assign head_we  = reg_we && (reg_kind == REG_HEAD);
  assign steer_we = reg_we && (reg_kind == REG_STEER);

  msi_evq_steer #(.NUM_Q(NUM_Q), .VEC_W(VEC_W), .QW(QW)) u_steer (
    .clk(clk), .rst_n(rst_n),
    .wr_en(steer_we), .wr_vec(reg_idx), .wr_q(reg_wdata[QW-1:0]),
    .rd_vec(msi_vector), .rd_q(tgt_q)
  );

  msi_evq_ptrs #(.NUM_Q(NUM_Q), .PTR_W(PTR_W), .QW(QW)) u_ptrs (
    .clk(clk), .rst_n(rst_n),
    .base_we(base_we), .head_we(head_we), .wq(reg_idx[QW-1:0]), .wdata(reg_wdata),
    .commit_en(commit_en), .commit_q(commit_q),
    .sel_q(tgt_q), .sel_full(tgt_full), .sel_addr(tgt_addr),
    .irq(irq)
  );

  msi_evq_engine #(.VEC_W(VEC_W), .QW(QW)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .msi_valid(msi_valid), .msi_vector(msi_vector), .msi_data(msi_data),
    .msi_ready(msi_ready),
    .tgt_q(tgt_q), .tgt_full(tgt_full), .tgt_addr(tgt_addr),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack),
    .commit_en(commit_en), .commit_q(commit_q)
  );

  // a full target queue never gets a new entry
  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (msi_valid && tgt_full) |=> !$rose(mem_wr_valid));
endmodule

// File: tb/sim_msi_evq_ctrl.sv
module sim_msi_evq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int VW = 6;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst_n;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic          msi_valid, mem_wr_ack, reg_we;
  logic [VW-1:0] msi_vector, reg_idx;
  logic [15:0]   msi_data;
  logic [1:0]    reg_kind;
  logic [31:0]   reg_wdata;
  logic          msi_ready, mem_wr_valid;
  logic [31:0]   mem_wr_addr, mem_wr_data;
  logic [NQ-1:0] irq;

  msi_evq_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .msi_valid(msi_valid), .msi_vector(msi_vector), .msi_data(msi_data),
    .msi_ready(msi_ready),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .mem_wr_ack(mem_wr_ack),
    .reg_we(reg_we), .reg_kind(reg_kind), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .irq(irq)
  );

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // behavioural model
  logic [31:0] m_base [NQ];
  int m_head [NQ];
  int m_tail [NQ];
  int m_route [DEPTH];
  bit m_busy;
  int m_q;
  logic [31:0] m_addr, m_data;
  int m_wait;
  int ack_lat;
  bit m_accepted;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_full(input int q);
    return ((m_tail[q] + 1) % DEPTH) == m_head[q];
  endfunction

  task automatic tick();
    bit exp_ready, acc, ack;
    logic [NQ-1:0] exp_irq;
    mem_wr_ack = m_busy && (m_wait >= ack_lat);
    #1;
    exp_ready = !m_busy && !m_full(m_route[msi_vector]);
    chk(msi_ready == exp_ready, "R3 R6 msi_ready", 64'(msi_ready), 64'(exp_ready));
    chk(mem_wr_valid == m_busy, "R3 write request", 64'(mem_wr_valid), 64'(m_busy));
    if (m_busy) begin
      chk(mem_wr_addr == m_addr, "R1 R10 entry address", 64'(mem_wr_addr), 64'(m_addr));
      chk(mem_wr_data == m_data, "R2 entry word", 64'(mem_wr_data), 64'(m_data));
    end
    for (int q = 0; q < NQ; q++) exp_irq[q] = (m_head[q] != m_tail[q]);
    chk(irq == exp_irq, "R4 R5 irq lines", 64'(irq), 64'(exp_irq));
    acc = msi_valid && exp_ready;
    ack = mem_wr_ack;
    @(posedge clk);
    if (m_busy) begin
      if (ack) begin
        m_tail[m_q] = (m_tail[m_q] + 1) % DEPTH;
        m_busy = 0;
      end else m_wait++;
    end else if (acc) begin
      m_q = m_route[msi_vector];
      m_addr = m_base[m_q] + 32'(4 * m_tail[m_q]);
      m_data = {16'(msi_vector), msi_data};
      m_busy = 1;
      m_wait = 0;
      m_accepted = 1;
    end
    if (reg_we) begin
      case (reg_kind)
        2'd0: m_base[reg_idx % NQ] = reg_wdata;
        2'd1: m_head[reg_idx % NQ] = int'(reg_wdata[5:0]);
        2'd2: m_route[reg_idx] = int'(reg_wdata[1:0]);
        default: ;
      endcase
    end
    @(negedge clk);
    mem_wr_ack = 1'b0;
  endtask

  task automatic send(input int vec, input int dat);
    int n = 0;
    msi_valid = 1'b1; msi_vector = VW'(vec); msi_data = 16'(dat);
    m_accepted = 0;
    while (!m_accepted && n < 200) begin tick(); n++; end
    msi_valid = 1'b0;
    while (m_busy) tick();
  endtask

  task automatic regw(input int kind, input int idx, input logic [31:0] val);
    reg_we = 1'b1; reg_kind = 2'(kind); reg_idx = VW'(idx); reg_wdata = val;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; msi_valid = 0; msi_vector = '0; msi_data = '0; mem_wr_ack = 0;
    reg_we = 0; reg_kind = '0; reg_idx = '0; reg_wdata = '0;
    ack_lat = 1; m_busy = 0; m_wait = 0; m_q = 0; m_accepted = 0;
    for (int q = 0; q < NQ; q++) begin m_base[q] = '0; m_head[q] = 0; m_tail[q] = 0; end
    for (int v = 0; v < DEPTH; v++) m_route[v] = v % NQ;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(irq == '0, "R9 irq after reset", 64'(irq), 64'(0));
    chk(mem_wr_valid == 1'b0, "R9 no request after reset", 64'(mem_wr_valid), 64'(0));
    chk(msi_ready == 1'b1, "R9 ready after reset", 64'(msi_ready), 64'(1));
    rst_n = 1'b1;
    tick();
    // R9 zero base: first entry of queue 2 lands at address 0
    send(2, 16'h1234);

    // R8 bases, then a kind-3 write that must change nothing
    for (int q = 0; q < NQ; q++) regw(0, q, 32'h1000_0000 + 32'(q) * 32'h1000);
    regw(3, 0, 32'hDEAD_BEEF);
    regw(3, 1, 32'h0000_0005);

    // R1 R2 R4 main path with different acknowledge latencies
    for (int v = 0; v < 8; v++) begin
      ack_lat = v % 4;
      send(v, 16'hA500 + v);
    end
    chk(irq == 4'hF, "R4 all queues pending", 64'(irq), 64'hF);

    // R5 software catches up on each queue
    for (int q = 0; q < NQ; q++) regw(1, q, 32'(m_tail[q]));
    chk(irq == 4'h0, "R5 lines cleared", 64'(irq), 64'h0);

    // R7 retarget vector 5 from queue 1 to queue 3
    regw(2, 5, 32'd3);
    ack_lat = 2;
    send(5, 16'h0BEE);
    chk(irq == 4'h8, "R7 retargeted vector raises queue 3", 64'(irq), 64'h8);
    regw(1, 3, 32'(m_tail[3]));

    // R6 R10 fill queue 0 through the wrap
    ack_lat = 0;
    for (int k = 0; k < 63; k++) send((k % 2) * 4, k);
    chk(m_full(0), "R6 model full", 64'(m_full(0)), 64'(1));
    msi_valid = 1'b1; msi_vector = VW'(0); msi_data = 16'hFFFF; m_accepted = 0;
    repeat (6) tick();
    chk(!m_accepted && !mem_wr_valid, "R6 held off while full", 64'(mem_wr_valid), 64'(0));
    msi_valid = 1'b0;
    // R6 another queue still takes traffic
    send(1, 16'h0111);
    chk(irq[1] == 1'b1, "R6 other queue accepted", 64'(irq[1]), 64'(1));
    // free one slot, the held message goes in
    regw(1, 0, 32'((m_head[0] + 1) % DEPTH));
    send(0, 16'h7777);
    regw(1, 0, 32'(m_tail[0]));
    regw(1, 1, 32'(m_tail[1]));
    ack_lat = 3;
    send(4, 16'h4444);
    chk(irq == 4'h1, "R5 only queue 0 pending", 64'(irq), 64'h1);
    repeat (3) tick();

    done = 1;
    summary();
    $finish;
  end
endmodule